// File: doc/BRIEF.md
# Burst Address Sequencer with Linear and Interleaved Ordering

This block generates the word address for each beat of a four-beat burst in a synchronous burst memory. A burst starts when either address strobe is low on a rising clock edge and all three chip-select inputs are in their active state. On that edge the block captures the full address. The upper bits select the group of four words. The two low bits are the starting offset inside that group.

After the load, an active-low advance input moves the burst forward by one beat on each clock where it is low. When advance is high, the current beat is held. The output carries the captured upper bits unchanged. Its two low bits are the starting offset combined with a beat count. In linear order the count is added to the offset modulo four. In interleaved order the count is XOR-ed into the offset. The order input is captured together with the address. A last-beat flag marks the fourth beat. Advancing past the fourth beat returns to the first beat of the same group and never carries into the upper bits. A new qualified strobe always starts a fresh burst, even in a cycle where advance is also low.

Top module: `burst_addr_seq`

## Requirements
- R1: While and after synchronous reset, with no load since reset, `word_addr` is 0 and `last_beat` is 0.
- R2: A load occurs on a rising edge where (`strobe_p_n`==0 or `strobe_c_n`==0) and `cs1_n`==0, `cs2`==1 and `cs3_n`==0. After that edge, `word_addr` equals the captured `addr_in` and `last_beat` is 0.
- R3: If any chip select is inactive, or both strobes are high, no load occurs. With `adv_n`==1, `word_addr` and `last_beat` then keep their previous values.
- R4: After a load, each edge with `adv_n`==0 and no load advances the beat count by one. Each edge with `adv_n`==1 and no load holds both outputs.
- R5: With `order_sel`==0 captured at load (linear), beat k (k=0..3) presents low bits (start+k) mod 4. For example, 01 gives 01,10,11,00.
- R6: With `order_sel`==1 captured at load (interleaved, the intended default strap), beat k presents start XOR k. The four orders are 00,01,10,11 / 01,00,11,10 / 10,11,00,01 / 11,10,01,00.
- R7: `word_addr[ADDR_W-1:2]` holds the loaded upper bits for the whole burst, including after a wrap.
- R8: `last_beat` is 1 exactly while the fourth beat (k=3) is presented.
- R9: An advance from the fourth beat returns to the first beat (k=0) of the same group.
- R10: A load on an edge where `adv_n`==0 takes priority and starts a new burst at beat 0.
- R11: A change of `order_sel` between loads has no effect on the running burst.
- R12: Advance pulses before the first load after reset leave the outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| strobe_p_n | input | 1 | First address strobe, active low |
| strobe_c_n | input | 1 | Second address strobe, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Beat advance, active low |
| order_sel | input | 1 | 1 = interleaved, 0 = linear; captured at load |
| word_addr | output | ADDR_W | Current beat word address |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The assertions assume that every input is driven to a known 0 or 1 at each rising edge, and that reset is high from time zero. The bench drives all inputs on the falling edge, so they are stable around every rising edge. It asserts reset before the first clock. The bench also changes `order_sel` during running bursts. This has no effect on the properties, because they depend only on the strobe and chip-select qualification and on `adv_n`.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int unsigned BURST_LEN = 4;
    localparam int unsigned BEAT_W    = $clog2(BURST_LEN);

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic   active;
        order_e order;
        beat_t  start;
        beat_t  count;
    } burst_st_t;

    function automatic beat_t map_beat(order_e ord, beat_t start, beat_t count);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ count;
        else                       r = start + count;
        return r;
    endfunction
endpackage

// File: rtl/bseq_qualify.sv
module bseq_qualify (
    input  logic strobe_p_n,
    input  logic strobe_c_n,
    input  logic cs1_n,
    input  logic cs2,
    input  logic cs3_n,
    output logic load
);
    logic selected;
    logic strobed;

    always_comb begin
        selected = ~cs1_n & cs2 & ~cs3_n;
        strobed  = ~strobe_p_n | ~strobe_c_n;
        load     = selected & strobed;
    end
endmodule

// File: rtl/bseq_core.sv
module bseq_core
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   adv_n,
    input  logic                   order_sel,
    input  logic [ADDR_W-1:0]      addr_in,
    output burst_st_t              st,
    output logic [ADDR_W-BEAT_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            base <= '0;
        end else if (load) begin
            st.active <= 1'b1;
            st.order  <= order_e'(order_sel);
            st.start  <= addr_in[BEAT_W-1:0];
            st.count  <= '0;
            base      <= addr_in[ADDR_W-1:BEAT_W];
        end else if (st.active && !adv_n) begin
            st.count  <= st.count + beat_t'(1);
        end
    end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  burst_st_t                st,
    input  logic [ADDR_W-BEAT_W-1:0] base,
    output logic [ADDR_W-1:0]        word_addr,
    output logic                     last_beat
);
    localparam beat_t FINAL_BEAT = beat_t'(BURST_LEN - 1);

    beat_t low_bits;

    always_comb begin
        low_bits  = map_beat(st.order, st.start, st.count);
        word_addr = st.active ? {base, low_bits} : '0;
        last_beat = st.active && (st.count == FINAL_BEAT);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] word_addr,
    output logic              last_beat
);
    logic                     load;
    burst_st_t                st;
    logic [ADDR_W-BEAT_W-1:0] base;

    bseq_qualify u_qual (
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .load       (load)
    );

    bseq_core #(.ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .adv_n     (adv_n),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .st        (st),
        .base      (base)
    );

    bseq_order #(.ADDR_W(ADDR_W)) u_order (
        .st        (st),
        .base      (base),
        .word_addr (word_addr),
        .last_beat (last_beat)
    );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_p_n,
    input logic              strobe_c_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] word_addr,
    input logic              last_beat
);
    logic qual;
    logic seen_load;

    assign qual = (!strobe_p_n || !strobe_c_n) && !cs1_n && cs2 && !cs3_n;

    always_ff @(posedge clk) begin
        if (rst)       seen_load <= 1'b0;
        else if (qual) seen_load <= 1'b1;
    end

    a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
        qual |=> (word_addr == $past(addr_in)) && !last_beat);

    a_r3_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!qual && adv_n) |=> $stable(word_addr) && $stable(last_beat));

    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !qual |=> $stable(word_addr[ADDR_W-1:2]));

    a_r8_single_last: assert property (@(posedge clk) disable iff (rst)
        (last_beat && !adv_n && !qual) |=> !last_beat);

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !seen_load |-> (word_addr == '0) && !last_beat);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_in    (addr_in),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .adv_n      (adv_n),
    .word_addr  (word_addr),
    .last_beat  (last_beat)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_p_n = 1'b1, strobe_c_n = 1'b1;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic          adv_n = 1'b1, order_sel = 1'b1;
    logic [AW-1:0] word_addr;
    logic          last_beat;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv_n(adv_n), .order_sel(order_sel),
        .word_addr(word_addr), .last_beat(last_beat)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic          last;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model state
    logic          m_act = 0, m_ord = 0;
    logic [1:0]    m_start = 0, m_k = 0;
    logic [AW-3:0] m_base = 0;

    function automatic logic [1:0] ref_low(logic ord, logic [1:0] s, logic [1:0] k);
        logic [1:0] r;
        if (ord) begin
            case (s)
                2'b00: r = k;
                2'b01: case (k) 0: r = 2'b01; 1: r = 2'b00; 2: r = 2'b11; default: r = 2'b10; endcase
                2'b10: case (k) 0: r = 2'b10; 1: r = 2'b11; 2: r = 2'b00; default: r = 2'b01; endcase
                default: case (k) 0: r = 2'b11; 1: r = 2'b10; 2: r = 2'b01; default: r = 2'b00; endcase
            endcase
        end else begin
            r = 2'((int'(s) + int'(k)) % 4);
        end
        return r;
    endfunction

    task automatic step(input logic [AW-1:0] a, input logic sp, input logic sc,
                        input logic e1, input logic e2, input logic e3,
                        input logic adv, input logic ord, input string tag);
        exp_t e;
        logic ld;
        @(negedge clk);
        addr_in = a; strobe_p_n = sp; strobe_c_n = sc;
        cs1_n = e1; cs2 = e2; cs3_n = e3; adv_n = adv; order_sel = ord;
        ld = (!sp || !sc) && !e1 && e2 && !e3;
        if (ld) begin
            m_act = 1; m_ord = ord; m_start = a[1:0]; m_k = 0; m_base = a[AW-1:2];
        end else if (m_act && !adv) begin
            m_k = m_k + 2'd1;
        end
        e.addr = m_act ? {m_base, ref_low(m_ord, m_start, m_k)} : '0;
        e.last = m_act && (m_k == 2'd3);
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic load_p(input logic [AW-1:0] a, input logic ord, input string tag);
        step(a, 0, 1, 0, 1, 0, 1, ord, tag);
    endtask
    task automatic adv(input logic ord, input string tag);
        step(addr_in, 1, 1, 0, 1, 0, 0, ord, tag);
    endtask
    task automatic idle(input string tag);
        step(addr_in, 1, 1, 0, 1, 0, 1, order_sel, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (word_addr !== e.addr || last_beat !== e.last) begin
                    n_bad++;
                    $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                             e.tag, word_addr, last_beat, e.addr, e.last);
                end
            end
        end
    end

    // watchdog
    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (word_addr !== '0 || last_beat !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: addr=%h last=%b expected addr=0 last=0", word_addr, last_beat);
        end
        rst = 0;
        // R1 / R12: advancing before any load
        idle("R1 idle after reset");
        adv(1, "R12 advance before load");
        adv(1, "R12 advance before load");

        // R2 R5 R8 R9 R7: linear burst via first strobe
        load_p(17'h1_2345, 0, "R2 load linear");
        for (int i = 0; i < 5; i++) adv(0, "R5 R8 R9 R7 linear beat");
        idle("R4 hold");
        idle("R4 hold");

        // R6 interleaved, every start, second strobe
        for (int s = 0; s < 4; s++) begin
            step({15'h5A5A, 2'(s)}, 1, 0, 0, 1, 0, 1, 1, "R2 load second strobe");
            for (int i = 0; i < 4; i++) adv(1, "R6 R8 R9 interleaved beat");
            idle("R4 hold interleaved");
        end

        // R5 linear, every start
        for (int s = 0; s < 4; s++) begin
            load_p({15'h0F0F, 2'(s)}, 0, "R2 load linear");
            for (int i = 0; i < 4; i++) adv(0, "R5 R9 linear beat");
        end

        // R3 blocked loads
        load_p(17'h0_0006, 1, "R2 load");
        adv(1, "R4 advance");
        step(17'h1_FFFD, 0, 0, 1, 1, 0, 1, 1, "R3 cs1 inactive");
        step(17'h1_FFFD, 0, 0, 0, 0, 0, 1, 1, "R3 cs2 inactive");
        step(17'h1_FFFD, 0, 0, 0, 1, 1, 1, 1, "R3 cs3 inactive");
        step(17'h1_FFFD, 1, 1, 0, 1, 0, 1, 1, "R3 no strobe");

        // R10 load wins over advance
        adv(1, "R4 advance");
        step(17'h0_7771, 0, 1, 0, 1, 0, 0, 0, "R10 load with advance");
        adv(0, "R10 continue");

        // R11 order change mid burst ignored
        load_p(17'h1_0002, 1, "R2 load interleaved");
        adv(0, "R11 order toggled");
        adv(0, "R11 order toggled");
        adv(1, "R11 order toggled");
        adv(0, "R11 R9 wrap");

        idle("final");
        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule